// File: doc/BRIEF.md
# Interrupt Enable and Flag Register

This block is the 8-bit interrupt control register of a small microcontroller. It holds a global enable, an enable for the peripheral group, enables for three local sources, and a flag for each of those sources. The three sources are a timer overflow strobe, a rising edge on an external interrupt pin, and a change on a 4-bit input port. The block combines the enabled sources with a pending line from the peripheral group and drives one interrupt request to the CPU.

A flag latches when its event occurs, whatever the enable bits hold, and stays set until software writes it clear. The external pin and the port nibble pass through two-flop synchronizers. The port source compares the synchronized nibble against a snapshot that is taken on each port read strobe. The CPU's acknowledge strobe clears the global enable, and its return strobe sets it again.

Top module: `irq_ctl`

## Requirements
- R1: `rd_data` always shows the register. Bit 7 is the global enable, bit 6 the peripheral enable, bit 5 the timer enable, bit 4 the pin enable and bit 3 the port enable. Bit 2 is the timer flag, bit 1 the pin flag and bit 0 the port flag. When no event or strobe is present, a write with `wr_en` loads all eight bits from `wr_data`, and the new value is visible after that clock edge.
- R2: Synchronous active-low reset clears every bit of the register, including the port flag, and holds `irq_req` low.
- R3: A `tmr_ovf` high at a clock edge sets bit 2 at that edge, whatever the value of any enable bit.
- R4: Flags stay set until a write puts 0 in them. If a write clears a flag at the same edge its event sets it, the flag ends set.
- R5: A 0-to-1 change on `ext_pin` sets bit 1 at the third clock edge after the pin changes. A pulse lasting one cycle is enough. A 1-to-0 change never sets the flag.
- R6: When the synchronized `port_in` differs from the snapshot, bit 0 is set. A new port value sets the flag at the third clock edge after it is applied.
- R7: A `port_rd` strobe loads the snapshot from the synchronized port. While the port still differs from the snapshot, a clearing write leaves bit 0 set. After a read, the same write leaves it clear.
- R8: `irq_req` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0) OR (bit6 AND `periph_pend`)). It is combinational from the register and `periph_pend`.
- R9: `irq_ack` clears bit 7 and `irq_ret` sets it. When both strobes arrive together, the acknowledge wins. Either strobe overrides the value of bit 7 written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value |
| tmr_ovf | input | 1 | Timer overflow strobe, one cycle |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_in | input | 4 | Watched port nibble, asynchronous |
| port_rd | input | 1 | Port read strobe, loads the snapshot |
| periph_pend | input | 1 | Pending request from the peripheral group |
| irq_ack | input | 1 | CPU accepted the interrupt |
| irq_ret | input | 1 | CPU returned from the interrupt |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
Every fault inside this block shows on `rd_data` or `irq_req`, and usually within one to three cycles. A register bit with the wrong value shows on the next read, because the read port reflects the register directly. Any error in the request gating shows in the same cycle on `irq_req`. A fault in a synchronizer or an edge detector moves the cycle in which a flag appears, or lets a falling edge set the flag. A snapshot fault either leaves the port flag unable to clear after a read, or keeps it from setting on a change, and the bench sees this at the cycle it expects.

// File: rtl/irq_ctl_pkg.sv
// Shared register layout for the interrupt control register.
// Assumes an 8-bit register with the field order fixed by the read port.
package irq_ctl_pkg;
    localparam int REG_W = 8;

    typedef struct packed {
        logic gie;       // bit 7 global enable
        logic peie;      // bit 6 peripheral group enable
        logic tmr_en;    // bit 5
        logic ext_en;    // bit 4
        logic chg_en;    // bit 3
        logic tmr_flag;  // bit 2
        logic ext_flag;  // bit 1
        logic chg_flag;  // bit 0
    } ctl_reg_t;
endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchronizer for asynchronous inputs.
// Assumes STAGES >= 1; the output is the last stage, reset to zero.
module irq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // purpose: capture the raw input
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= d;
            end
        end else begin : g_next
            // purpose: pass the value along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else        chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
// Synchronizes a pin and produces a one-cycle pulse on each rising edge.
// Assumes the pin is asynchronous to clk.
module irq_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    logic pin_s;
    logic pin_prev;

    irq_sync #(.W(1), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s)
    );

    // purpose: remember the previous synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= pin_s;
    end

    assign rise = pin_s & ~pin_prev;

    assert_rise_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/irq_port_watch.sv
// Watches a port nibble and flags a difference from a snapshot.
// Assumes the snapshot is loaded by the port read strobe.
module irq_port_watch #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] port,
    input  logic         capture,
    output logic         differ
);
    logic [W-1:0] port_s;
    logic [W-1:0] snap;

    irq_sync #(.W(W), .STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(port), .q(port_s)
    );

    // purpose: hold the port value seen at the last read
    always_ff @(posedge clk) begin
        if (!rst_n)       snap <= '0;
        else if (capture) snap <= port_s;
    end

    assign differ = (port_s != snap);

    assert_read_settles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && $stable(port_s)) |=> !differ);
endmodule

// File: rtl/irq_gate.sv
// Two-level gating of interrupt sources into a single request.
// Assumes flags and enables come straight from the control register.
module irq_gate (
    input  irq_ctl_pkg::ctl_reg_t r,
    input  logic                  periph_pend,
    output logic                  req
);
    logic [3:0] en_vec;
    logic [3:0] src_vec;

    // purpose: pair each source with its enable
    always_comb begin
        en_vec  = {r.tmr_en,   r.ext_en,   r.chg_en,   r.peie};
        src_vec = {r.tmr_flag, r.ext_flag, r.chg_flag, periph_pend};
        req     = r.gie & |(en_vec & src_vec);
    end
endmodule

// File: rtl/irq_ctl.sv
// Interrupt control and flag register: enables, sticky flags, request output.
// Assumes tmr_ovf, wr_en and the CPU strobes are synchronous to clk.
module irq_ctl #(
    parameter int PORT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              tmr_ovf,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_in,
    input  logic              port_rd,
    input  logic              periph_pend,
    input  logic              irq_ack,
    input  logic              irq_ret,
    output logic              irq_req
);
    import irq_ctl_pkg::*;

    ctl_reg_t r, r_nxt;
    logic     ext_rise;
    logic     chg_diff;

    irq_edge_det #(.STAGES(SYNC_STAGES)) u_ext (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .rise(ext_rise)
    );

    irq_port_watch #(.W(PORT_W), .STAGES(SYNC_STAGES)) u_port (
        .clk(clk), .rst_n(rst_n), .port(port_in), .capture(port_rd),
        .differ(chg_diff)
    );

    // purpose: next register value; events over writes, strobes over writes
    always_comb begin
        r_nxt = wr_en ? ctl_reg_t'(wr_data) : r;
        if (irq_ack)      r_nxt.gie = 1'b0;
        else if (irq_ret) r_nxt.gie = 1'b1;
        r_nxt.tmr_flag = r_nxt.tmr_flag | tmr_ovf;
        r_nxt.ext_flag = r_nxt.ext_flag | ext_rise;
        r_nxt.chg_flag = r_nxt.chg_flag | chg_diff;
    end

    // purpose: the register itself
    always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else        r <= r_nxt;
    end

    irq_gate u_gate (.r(r), .periph_pend(periph_pend), .req(irq_req));

    assign rd_data = r;

    assert_tmr_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> r.tmr_flag);
    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r.tmr_flag && !wr_en) |=> r.tmr_flag);
    assert_ext_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> r.ext_flag);
    assert_chg_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chg_diff |=> r.chg_flag);
    assert_ack_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !r.gie);
    assert_ret_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !irq_ack) |=> r.gie);
endmodule

// File: tb/irq_ctl_test.sv
module irq_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       tmr_ovf = 1'b0;
    logic       ext_pin = 1'b0;
    logic [3:0] port_in = 4'h0;
    logic       port_rd = 1'b0;
    logic       periph_pend = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_ret = 1'b0;
    logic       irq_req;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    irq_ctl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
        .port_in(port_in), .port_rd(port_rd), .periph_pend(periph_pend),
        .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        step();
        wr_en = 1'b0;
    endtask

    function automatic logic exp_irq(input logic [7:0] v, input logic p);
        return v[7] & ((v[5] & v[2]) | (v[4] & v[1]) | (v[3] & v[0]) | (v[6] & p));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [3:0] snap;
        step(); step(); step();
        // R2: reset state
        chk("R2 reset reg", rd_data, 8'h00);
        chk("R2 reset irq", {7'b0, irq_req}, 8'h00);
        rst_n = 1'b1;
        step();
        chk("R2 after release", rd_data, 8'h00);

        // R1 and R8: every register value with both pending levels
        for (int v = 0; v < 256; v++) begin
            for (int p = 0; p < 2; p++) begin
                periph_pend = p[0];
                wr(v[7:0]);
                chk("R1 write/read", rd_data, v[7:0]);
                chk("R8 request", {7'b0, irq_req}, {7'b0, exp_irq(v[7:0], p[0])});
            end
        end
        periph_pend = 1'b0;
        wr(8'h00);

        // R3: timer flag under every enable pattern
        for (int g = 0; g < 2; g++) begin
            for (int e = 0; e < 8; e++) begin
                wr({g[0], 1'b0, e[2:0], 3'b000});
                tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
                chk("R3 timer flag", rd_data, {g[0], 1'b0, e[2:0], 3'b100});
                chk("R8 timer request", {7'b0, irq_req}, {7'b0, g[0] & e[2]});
            end
        end
        wr(8'h00);

        // R4: sticky flag and set-wins
        tmr_ovf = 1'b1; step(); tmr_ovf = 1'b0;
        step(); step(); step();
        chk("R4 sticky", rd_data, 8'h04);
        wr_en = 1'b1; wr_data = 8'h00; tmr_ovf = 1'b1;
        step();
        wr_en = 1'b0; tmr_ovf = 1'b0;
        chk("R4 set wins", rd_data, 8'h04);
        wr(8'h00);
        chk("R4 write clears", rd_data, 8'h00);

        // R5: pin edge latency, held high and one-cycle pulse
        for (int w = 0; w < 2; w++) begin
            ext_pin = 1'b1;
            step();
            if (w == 1) ext_pin = 1'b0;
            chk("R5 edge+1", rd_data, 8'h00);
            step();
            chk("R5 edge+2", rd_data, 8'h00);
            step();
            chk("R5 edge+3", rd_data, 8'h02);
            wr(8'h00);
            ext_pin = 1'b0;
            step(); step(); step(); step();
            chk("R5 fall ignored", rd_data, 8'h00);
        end

        // R6 and R7: port change sweep over a spread of values
        snap = 4'h0;
        for (int i = 0; i < 32; i++) begin
            logic [3:0] nv;
            nv = 4'((i * 7 + 3) & 15);
            port_in = nv;
            step(); step();
            chk("R6 edge+2", rd_data, 8'h00);
            step();
            chk("R6 edge+3", rd_data, {7'b0, nv != snap});
            if (nv != snap) begin
                wr(8'h00);
                chk("R7 clear before read", rd_data, 8'h01);
            end
            port_rd = 1'b1; step(); port_rd = 1'b0;
            wr(8'h00);
            chk("R7 clear after read", rd_data, 8'h00);
            step();
            chk("R7 stays clear", rd_data, 8'h00);
            snap = nv;
        end

        // R9: acknowledge and return
        wr(8'hA4);
        chk("R9 req on", {7'b0, irq_req}, 8'h01);
        irq_ack = 1'b1; step(); irq_ack = 1'b0;
        chk("R9 ack clears", rd_data, 8'h24);
        chk("R9 req off", {7'b0, irq_req}, 8'h00);
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
        chk("R9 ret sets", rd_data, 8'hA4);
        irq_ack = 1'b1; irq_ret = 1'b1; step(); irq_ack = 1'b0; irq_ret = 1'b0;
        chk("R9 ack wins", rd_data, 8'h24);
        wr_en = 1'b1; wr_data = 8'hA4; irq_ack = 1'b1;
        step();
        wr_en = 1'b0; irq_ack = 1'b0;
        chk("R9 ack over write", rd_data, 8'h24);
        wr_en = 1'b1; wr_data = 8'h24; irq_ret = 1'b1;
        step();
        wr_en = 1'b0; irq_ret = 1'b0;
        chk("R9 ret over write", rd_data, 8'hA4);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule